// File: doc/BRIEF.md
# TDM Multichannel Transmit Selector

This block is the transmit half of a time-division-multiplexed serial port. A frame carries a fixed number of channel slots (32 by default), each one word of 8 bits sent most significant bit first, back to back after a frame-sync pulse. For every slot the block makes two separate decisions. The first is whether the slot is *taken*: it consumes a word from the holding register. The second is whether the slot is *driven*: the data pin is enabled for it. Data outside driven slots is held in high impedance through a low output-enable.

A 2-bit selection mode decides how the two decisions are derived from a transmit slot vector and a receive slot vector. Bit n of either vector belongs to channel n, so the value 0x0000000A names channels 1 and 3. The host feeds words through a single-entry valid/ready write port. `wr_ready` high means the holding register is free. A word is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` then stays low until a taken slot copies the word into the shift register. The host may hold `wr_valid` high with no limit; nothing is lost under back-pressure. When a taken slot starts with no new word present, the previous word is sent again and a sticky underflow flag is raised.

All logic runs on `clk`. The serial bit clock arrives as the one-cycle strobe `bit_en`. Frame sync is looked at only on `bit_en` cycles. The mode and both vectors are captured at each frame sync and stay fixed for that frame.

Top module: `tdm_tx_selector`

## Requirements
- R1: After reset, `dx_oe` is 0, `dx` is 0, `wr_ready` is 1 and `underflow` is 0.
- R2: In mode 0, every slot of the frame is taken and driven.
- R3: In mode 1, only slots whose bit is set in the transmit vector are taken and driven. Other slots consume no word and keep `dx_oe` low. Whenever `dx_oe` is low, `dx` is 0.
- R4: In mode 2, every slot is taken. Only slots whose transmit-vector bit is set are driven.
- R5: In mode 3, a slot is taken when its receive-vector bit is set. It is driven only when it is taken and its transmit-vector bit is also set.
- R6: `fsync` high on a `bit_en` cycle starts channel 0. Each slot lasts 8 `bit_en` cycles and sends its word MSB first on `dx`. The next channel follows at once. After the last channel, `dx_oe` stays low until the next frame sync. `dx_oe` changes only in the cycle after a `bit_en` cycle.
- R7: Each taken slot copies the holding register into the shift register and sets `wr_ready` to 1. An accepted write clears `wr_ready` on the next cycle.
- R8: A taken slot that starts while `wr_ready` is 1 resends the last copied word and sets `underflow`. `underflow` stays set until reset. If a write is accepted in that same cycle, the new word waits for the next taken slot.
- R9: Changes to `tx_mode`, `tx_chan_en` or `rx_chan_en` made during a frame have no effect until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per serial bit period |
| fsync | input | 1 | Frame sync, looked at only when bit_en is high |
| tx_mode | input | 2 | Slot selection mode 0..3 |
| tx_chan_en | input | CHANNELS | Transmit slot vector, bit n is channel n |
| rx_chan_en | input | CHANNELS | Receive slot vector, bit n is channel n |
| wr_valid | input | 1 | Host offers a word |
| wr_data | input | WORD_BITS | Word offered by the host |
| wr_ready | output | 1 | Holding register free; doubles as transmit-ready flag |
| dx | output | 1 | Serial data, 0 when not driven |
| dx_oe | output | 1 | Data pin output-enable, low means high impedance |
| underflow | output | 1 | Sticky flag set when a taken slot found no new word |

## Verification
Every result is registered once. `dx_oe` and the first bit of a slot on `dx` appear one clock after the `bit_en` edge that starts the slot. Each later bit appears one clock after its own `bit_en` edge. `wr_ready` and `underflow` change one clock after the handshake or copy edge. The bench drives inputs on the falling edge and advances an arithmetic slot model on the rising edge. It compares the outputs with that model on the next falling edge, so every check lands in the cycle after the edge that caused it. The bench sweeps all four modes over sparse, dense and edge-channel vectors, runs a producer-off stretch, and makes configuration changes in the middle of a frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [1:0] {
    SEL_ALL      = 2'd0,
    SEL_TX       = 2'd1,
    SEL_TX_MASK  = 2'd2,
    SEL_RX_TAKE  = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int CHANNELS  = 32,
  parameter int WORD_BITS = 8,
  localparam int SW = $clog2(CHANNELS),
  localparam int BW = $clog2(WORD_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          fsync,
  output logic          frame_start,
  output logic          slot_start,
  output logic          frame_end,
  output logic          bit_step,
  output logic [SW-1:0] next_slot
);
  logic          active_q;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic          last_bit;
  logic          last_slot;

  assign last_bit    = (bit_q == BW'(WORD_BITS - 1));
  assign last_slot   = (slot_q == SW'(CHANNELS - 1));
  assign frame_start = bit_en & fsync;
  assign slot_start  = frame_start | (bit_en & active_q & last_bit & ~last_slot);
  assign frame_end   = bit_en & ~fsync & active_q & last_bit & last_slot;
  assign bit_step    = bit_en & ~fsync & active_q & ~last_bit;
  assign next_slot   = frame_start ? '0 : slot_q + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else if (slot_start) begin
      active_q <= 1'b1;
      slot_q   <= next_slot;
      bit_q    <= '0;
    end else if (frame_end) begin
      active_q <= 1'b0;
    end else if (bit_step) begin
      bit_q <= bit_q + BW'(1);
    end
  end
endmodule

// File: rtl/tdm_chan_select.sv
module tdm_chan_select
  import tdm_tx_pkg::*;
#(
  parameter int CHANNELS = 32,
  localparam int SW = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [1:0]          mode_in,
  input  logic [CHANNELS-1:0] tx_in,
  input  logic [CHANNELS-1:0] rx_in,
  input  logic [SW-1:0]       slot,
  output logic                take,
  output logic                drive
);
  sel_mode_e           mode_q;
  logic [CHANNELS-1:0] tx_q;
  logic [CHANNELS-1:0] rx_q;
  sel_mode_e           mode_eff;
  logic [CHANNELS-1:0] tx_eff;
  logic [CHANNELS-1:0] rx_eff;
  logic [CHANNELS-1:0] take_vec;
  logic [CHANNELS-1:0] unmask_vec;

  // The frame that starts now already uses the incoming configuration.
  assign mode_eff = frame_start ? sel_mode_e'(mode_in) : mode_q;
  assign tx_eff   = frame_start ? tx_in : tx_q;
  assign rx_eff   = frame_start ? rx_in : rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SEL_ALL;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (frame_start) begin
      mode_q <= sel_mode_e'(mode_in);
      tx_q   <= tx_in;
      rx_q   <= rx_in;
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    always_comb begin
      unique case (mode_eff)
        SEL_ALL:     begin take_vec[c] = 1'b1;      unmask_vec[c] = 1'b1;      end
        SEL_TX:      begin take_vec[c] = tx_eff[c]; unmask_vec[c] = tx_eff[c]; end
        SEL_TX_MASK: begin take_vec[c] = 1'b1;      unmask_vec[c] = tx_eff[c]; end
        SEL_RX_TAKE: begin take_vec[c] = rx_eff[c]; unmask_vec[c] = tx_eff[c]; end
        default:     begin take_vec[c] = 1'b0;      unmask_vec[c] = 1'b0;      end
      endcase
    end
  end

  assign take  = take_vec[slot];
  assign drive = take_vec[slot] & unmask_vec[slot];
endmodule

// File: rtl/tdm_tx_hold.sv
module tdm_tx_hold #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic                 copy,
  output logic                 wr_ready,
  output logic [WORD_BITS-1:0] hold_word,
  output logic                 underflow
);
  logic                 pending_q;
  logic                 under_q;
  logic [WORD_BITS-1:0] hold_q;
  logic                 accept;

  assign accept    = wr_valid & ~pending_q;
  assign wr_ready  = ~pending_q;
  assign hold_word = hold_q;
  assign underflow = under_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      under_q   <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (copy && !pending_q) under_q <= 1'b1;
      if (accept) begin
        pending_q <= 1'b1;
        hold_q    <= wr_data;
      end else if (copy) begin
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_start,
  input  logic                 take,
  input  logic                 drive,
  input  logic                 frame_end,
  input  logic                 bit_step,
  input  logic [WORD_BITS-1:0] load_word,
  output logic                 dx,
  output logic                 dx_oe
);
  logic [WORD_BITS-1:0] sh_q;
  logic                 oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (slot_start) begin
      oe_q <= drive;
      if (take) sh_q <= load_word;
    end else if (frame_end) begin
      oe_q <= 1'b0;
    end else if (bit_step) begin
      sh_q <= {sh_q[WORD_BITS-2:0], 1'b0};
    end
  end

  assign dx    = oe_q & sh_q[WORD_BITS-1];
  assign dx_oe = oe_q;
endmodule

// File: rtl/tdm_tx_selector.sv
module tdm_tx_selector #(
  parameter int CHANNELS  = 32,
  parameter int WORD_BITS = 8,
  localparam int SW = $clog2(CHANNELS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 fsync,
  input  logic [1:0]           tx_mode,
  input  logic [CHANNELS-1:0]  tx_chan_en,
  input  logic [CHANNELS-1:0]  rx_chan_en,
  input  logic                 wr_valid,
  input  logic [WORD_BITS-1:0] wr_data,
  output logic                 wr_ready,
  output logic                 dx,
  output logic                 dx_oe,
  output logic                 underflow
);
  logic                 frame_start;
  logic                 slot_start;
  logic                 frame_end;
  logic                 bit_step;
  logic [SW-1:0]        next_slot;
  logic                 take;
  logic                 drive;
  logic [WORD_BITS-1:0] hold_word;

  tdm_slot_timer #(.CHANNELS(CHANNELS), .WORD_BITS(WORD_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .frame_start(frame_start), .slot_start(slot_start), .frame_end(frame_end),
    .bit_step(bit_step), .next_slot(next_slot)
  );

  tdm_chan_select #(.CHANNELS(CHANNELS)) u_select (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_in(tx_mode),
    .tx_in(tx_chan_en), .rx_in(rx_chan_en), .slot(next_slot),
    .take(take), .drive(drive)
  );

  tdm_tx_hold #(.WORD_BITS(WORD_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .copy(slot_start & take), .wr_ready(wr_ready), .hold_word(hold_word),
    .underflow(underflow)
  );

  tdm_tx_shift #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .take(take),
    .drive(drive), .frame_end(frame_end), .bit_step(bit_step),
    .load_word(hold_word), .dx(dx), .dx_oe(dx_oe)
  );
endmodule

// File: rtl/tdm_tx_selector_chk.sv
module tdm_tx_selector_chk #(
  parameter int CHANNELS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bit_en,
  input logic                fsync,
  input logic [1:0]          tx_mode,
  input logic [CHANNELS-1:0] tx_chan_en,
  input logic [CHANNELS-1:0] rx_chan_en,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic                dx,
  input logic                dx_oe,
  input logic                underflow
);
  // R2: channel 0 of a mode-0 frame is driven
  p_all_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync && tx_mode == 2'd0) |=> dx_oe);

  // R3: channel 0 stays quiet when its transmit bit is clear in mode 1
  p_sel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync && tx_mode == 2'd1 && !tx_chan_en[0]) |=> !dx_oe);

  // R3: data low while the pin is not driven
  p_dx_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_oe |-> !dx);

  // R4: channel 0 masked in mode 2 when its transmit bit is clear
  p_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync && tx_mode == 2'd2 && !tx_chan_en[0]) |=> !dx_oe);

  // R5: channel 0 not driven in mode 3 when its receive bit is clear
  p_rx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync && tx_mode == 2'd3 && !rx_chan_en[0]) |=> !dx_oe);

  // R6: output-enable moves only after a bit strobe
  p_oe_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(dx_oe));

  // R7: an accepted write drops ready
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R7: ready returns only through a copy on a bit strobe
  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !$rose(wr_ready));

  // R8: underflow is sticky
  p_under_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

bind tdm_tx_selector tdm_tx_selector_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
  .tx_mode(tx_mode), .tx_chan_en(tx_chan_en), .rx_chan_en(rx_chan_en),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .dx(dx), .dx_oe(dx_oe),
  .underflow(underflow)
);

// File: tb/tdm_tx_selector_test.sv
`timescale 1ns/1ps
module tdm_tx_selector_test;
  localparam int CH = 32;
  localparam int WB = 8;
  localparam int FT = CH * WB + 4;   // bit ticks between frame syncs

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic          fsync = 1'b0;
  logic [1:0]    tx_mode = 2'd0;
  logic [CH-1:0] tx_chan_en = '0;
  logic [CH-1:0] rx_chan_en = '0;
  logic          wr_valid = 1'b0;
  logic [WB-1:0] wr_data = '0;
  logic          wr_ready, dx, dx_oe, underflow;

  int total = 0;
  int bad = 0;
  bit prod_on = 1'b1;
  int cyc = 0;
  int tick = 0;

  // reference model state
  bit          m_active, m_oe, m_pending, m_under;
  int          m_slot, m_bit, m_ctr;
  logic [1:0]    m_mode;
  logic [CH-1:0] m_tx, m_rx;
  logic [WB-1:0] m_hold, m_word;

  always #5 clk = ~clk;

  tdm_tx_selector #(.CHANNELS(CH), .WORD_BITS(WB)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .tx_mode(tx_mode), .tx_chan_en(tx_chan_en), .rx_chan_en(rx_chan_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .dx(dx), .dx_oe(dx_oe), .underflow(underflow)
  );

  function automatic bit f_take(logic [1:0] md, logic [CH-1:0] tv, logic [CH-1:0] rv, int s);
    case (md)
      2'd0: return 1'b1;
      2'd1: return tv[s];
      2'd2: return 1'b1;
      default: return rv[s];
    endcase
  endfunction

  function automatic bit f_drive(logic [1:0] md, logic [CH-1:0] tv, logic [CH-1:0] rv, int s);
    return f_take(md, tv, rv, s) && (md == 2'd0 || tv[s]);
  endfunction

  always @(posedge clk) begin
    bit hs, st;
    if (!rst_n) begin
      m_active = 0; m_oe = 0; m_pending = 0; m_under = 0;
      m_slot = 0; m_bit = 0; m_ctr = 0;
      m_mode = '0; m_tx = '0; m_rx = '0; m_hold = '0; m_word = '0;
    end else begin
      hs = wr_valid && !m_pending;
      if (bit_en) begin
        st = 0;
        if (fsync) begin
          m_mode = tx_mode; m_tx = tx_chan_en; m_rx = rx_chan_en;
          m_active = 1; m_slot = 0; m_bit = 0; st = 1;
        end else if (m_active) begin
          if (m_bit == WB - 1) begin
            if (m_slot == CH - 1) begin m_active = 0; m_oe = 0; end
            else begin m_slot++; m_bit = 0; st = 1; end
          end else m_bit++;
        end
        if (st) begin
          m_oe = f_drive(m_mode, m_tx, m_rx, m_slot);
          if (f_take(m_mode, m_tx, m_rx, m_slot)) begin
            if (!m_pending) m_under = 1;
            m_word = m_hold;
            m_pending = 0;
          end
        end
      end
      if (hs) begin m_hold = wr_data; m_pending = 1; m_ctr++; end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string oe_tag();
    if (tx_mode != m_mode || tx_chan_en != m_tx || rx_chan_en != m_rx) return "R9";
    case (m_mode)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step();
    bit exp_dx;
    @(negedge clk);
    exp_dx = m_oe ? m_word[WB-1-m_bit] : 1'b0;
    chk(dx_oe == m_oe, {oe_tag(), " dx_oe"}, dx_oe, m_oe);
    chk(dx == exp_dx, "R6 dx bit", dx, exp_dx);
    chk(wr_ready == !m_pending, "R7 wr_ready", wr_ready, !m_pending);
    chk(underflow == m_under, "R8 underflow", underflow, m_under);
    cyc++;
    bit_en = cyc[0];
    fsync = 1'b0;
    if (bit_en) begin
      fsync = (tick % FT == 5);
      tick++;
    end
    wr_valid = prod_on;
    wr_data = WB'(m_ctr * 37 + 11);
  endtask

  task automatic run(logic [1:0] md, logic [CH-1:0] tv, logic [CH-1:0] rv, int n);
    tx_mode = md; tx_chan_en = tv; rx_chan_en = rv;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : wdog
    #3_000_000;
    bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dx_oe == 0, "R1 reset dx_oe", dx_oe, 0);
    chk(dx == 0, "R1 reset dx", dx, 0);
    chk(wr_ready == 1, "R1 reset wr_ready", wr_ready, 1);
    chk(underflow == 0, "R1 reset underflow", underflow, 0);
    rst_n = 1'b1;
    run(2'd0, '0, '0, 300);                                  // R2, starts mid-frame phase
    run(2'd1, 32'h0000_000A, '0, 2 * 2 * FT);                // R3, channels 1 and 3
    run(2'd1, 32'h8000_0001, '0, 2 * 2 * FT);                // R3, edge channels
    run(2'd2, 32'h0000_000A, '0, 2 * 2 * FT);                // R4
    run(2'd3, 32'h0000_000A, 32'h0000_0008, 2 * 2 * FT);     // R5
    run(2'd3, 32'h3C3C_3C3C, 32'hF0F0_F0F0, 2 * 2 * FT);     // R5
    run(2'd2, 32'hFFFF_0000, '0, 2 * 2 * FT);                // R4, R9 mid-frame change
    chk(underflow == 0, "R8 no underflow while fed", underflow, 0);
    prod_on = 1'b0;
    run(2'd0, '0, '0, 2 * 2 * FT);                           // R8 starve: resend + sticky
    chk(underflow == 1, "R8 sticky underflow", underflow, 1);
    prod_on = 1'b1;
    run(2'd1, 32'h5555_AAAA, '0, 2 * 2 * FT);                // R8 stays set, R3
    chk(underflow == 1, "R8 stays set", underflow, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule